// File: doc/BRIEF.md
# Decode-Stage Branch and Jump Resolver

This block sits in the decode stage of a 32-bit pipeline that has one branch delay slot. For each decoded instruction it works out whether the fetch stage must redirect, and where the new PC points. It handles three kinds of redirect: a conditional branch that is taken, a jump to an absolute target, and a jump to a register value. Conditional branches compare the forwarded operands directly, so the decision is known while the delay-slot instruction is being fetched. Hazard stalling and the instruction memory are handled elsewhere.

Every input is sampled on the rising clock edge while `id_valid` is high. The redirect flags and addresses are presented as registered outputs one cycle later, which is when the fetch stage loads its next PC. The delay-slot instruction has already been fetched by then, so it always executes. All pins are plain control and data. The block has no handshake: decode presents one instruction per cycle and fetch always accepts the result.

The condition logic relies on three helper flags taken from the operands: operand equality, rs strictly positive as a signed number, and rs equal to zero. The two branch targets are always formed from the delay-slot PC.

Top module: `branch_resolver`

## Requirements
- R1: During reset and in the first cycle after it, `br_taken`, `jmp_taken` and `jreg_taken` are 0, and `br_addr`, `jmp_addr` and `jreg_addr` are 0.
- R2: Opcode 4 (branch-if-equal) sets `br_taken` when `rs_val == rt_val`. Opcode 5 (branch-if-not-equal) sets it when they differ.
- R3: Opcode 7 sets `br_taken` when rs is strictly positive as a signed number. Opcode 6 sets it when rs is zero or negative.
- R4: Opcode 1 chooses its test with `rt_sel`. `rt_sel` 1 branches when rs is zero or positive, and `rt_sel` 0 branches when rs is negative. Every other `rt_sel` value redirects nothing.
- R5: Opcodes 2 and 3 set `jmp_taken`. `jmp_addr` is the top 4 bits of `slot_pc`, then the 26-bit `jtarget`, then two zero bits.
- R6: Opcode 0 with `funct` 8 or 9 sets `jreg_taken`, and `jreg_addr` equals `rs_val`. Opcode 0 with any other `funct` redirects nothing.
- R7: `br_addr` equals `slot_pc` plus the sign-extended 16-bit `imm` shifted left by two, wrapping modulo 2^32.
- R8: At most one of the three flags is high in any cycle. All flags are low after a cycle in which `id_valid` is low or the opcode is not one of 0 to 7.
- R9: Results appear on the outputs one clock edge after the inputs are sampled. The three address outputs keep their values across cycles in which `id_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds a real instruction this cycle |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field for opcode 0 |
| rt_sel | input | 5 | rt field, which selects the test for opcode 1 |
| imm | input | 16 | Branch offset in words |
| jtarget | input | 26 | Absolute jump field |
| rs_val | input | 32 | Forwarded rs operand |
| rt_val | input | 32 | Forwarded rt operand |
| slot_pc | input | 32 | PC of the delay-slot instruction |
| br_taken | output | 1 | Conditional branch taken |
| jmp_taken | output | 1 | Jump to absolute target |
| jreg_taken | output | 1 | Jump to register value |
| br_addr | output | 32 | Branch target |
| jmp_addr | output | 32 | Absolute jump target |
| jreg_addr | output | 32 | Register jump target |

## Verification
The redirect flags come straight from one registered redirect-kind value. An error in a helper flag shows up on the first instruction whose test depends on it. It appears as a wrong `br_taken` exactly one edge after that instruction is sampled, and the operand boundaries 0, 1, -1 and the most negative value expose it fastest. Errors in the address paths show as a wrong address on that same edge, or as a changed address after an idle cycle. The bench compares every output on every cycle, so any divergence is caught at the cycle where it first occurs.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;
  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_REGIMM  = 6'd1;
  localparam logic [5:0] OPC_JUMP    = 6'd2;
  localparam logic [5:0] OPC_JLINK   = 6'd3;
  localparam logic [5:0] OPC_BEQ     = 6'd4;
  localparam logic [5:0] OPC_BNE     = 6'd5;
  localparam logic [5:0] OPC_BLEZ    = 6'd6;
  localparam logic [5:0] OPC_BGTZ    = 6'd7;

  localparam logic [5:0] FN_JREG      = 6'd8;
  localparam logic [5:0] FN_JREG_LINK = 6'd9;

  localparam logic [4:0] SEL_NEG    = 5'd0;
  localparam logic [4:0] SEL_NONNEG = 5'd1;

  typedef enum logic [1:0] {
    RDIR_NONE   = 2'd0,
    RDIR_BRANCH = 2'd1,
    RDIR_JUMP   = 2'd2,
    RDIR_JREG   = 2'd3
  } redirect_e;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_resolver_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  input  logic [4:0]      rt_sel,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output redirect_e       kind
);
  logic ops_equal;
  logic rs_zero;
  logic rs_positive;

  // helper flags shared by all conditional tests
  assign ops_equal   = (rs_val == rt_val);
  assign rs_zero     = ~|rs_val;
  assign rs_positive = ~rs_val[XLEN-1] & ~rs_zero;

  always_comb begin
    kind = RDIR_NONE;
    case (opcode)
      OPC_SPECIAL:
        if (funct == FN_JREG || funct == FN_JREG_LINK) kind = RDIR_JREG;
      OPC_REGIMM: begin
        if (rt_sel == SEL_NONNEG && (rs_positive || rs_zero)) kind = RDIR_BRANCH;
        if (rt_sel == SEL_NEG && !(rs_positive || rs_zero))   kind = RDIR_BRANCH;
      end
      OPC_JUMP, OPC_JLINK: kind = RDIR_JUMP;
      OPC_BEQ:  if (ops_equal)    kind = RDIR_BRANCH;
      OPC_BNE:  if (!ops_equal)   kind = RDIR_BRANCH;
      OPC_BLEZ: if (!rs_positive) kind = RDIR_BRANCH;
      OPC_BGTZ: if (rs_positive)  kind = RDIR_BRANCH;
      default:  kind = RDIR_NONE;
    endcase
  end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  slot_pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] jtarget,
  output logic [XLEN-1:0]  br_addr,
  output logic [XLEN-1:0]  jmp_addr
);
  localparam int WORD_SH = 2;
  localparam int EXT_W   = XLEN - IMM_W - WORD_SH;
  localparam int REGION  = XLEN - TGT_W - WORD_SH;

  logic [XLEN-1:0] byte_offset;

  assign byte_offset = {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SH{1'b0}}};
  assign br_addr     = slot_pc + byte_offset;
  assign jmp_addr    = {slot_pc[XLEN-1 -: REGION], jtarget, {WORD_SH{1'b0}}};
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_resolver_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [5:0]       opcode,
  input  logic [5:0]       funct,
  input  logic [4:0]       rt_sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] jtarget,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [XLEN-1:0]  slot_pc,
  output logic             br_taken,
  output logic             jmp_taken,
  output logic             jreg_taken,
  output logic [XLEN-1:0]  br_addr,
  output logic [XLEN-1:0]  jmp_addr,
  output logic [XLEN-1:0]  jreg_addr
);
  redirect_e       kind_d;
  redirect_e       kind_q;
  logic [XLEN-1:0] br_addr_d;
  logic [XLEN-1:0] jmp_addr_d;

  branch_cond_eval #(.XLEN(XLEN)) u_cond (
    .opcode (opcode),
    .funct  (funct),
    .rt_sel (rt_sel),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .kind   (kind_d)
  );

  branch_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_tgt (
    .slot_pc  (slot_pc),
    .imm      (imm),
    .jtarget  (jtarget),
    .br_addr  (br_addr_d),
    .jmp_addr (jmp_addr_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= RDIR_NONE;
      br_addr   <= '0;
      jmp_addr  <= '0;
      jreg_addr <= '0;
    end else begin
      kind_q <= id_valid ? kind_d : RDIR_NONE;
      if (id_valid) begin
        br_addr   <= br_addr_d;
        jmp_addr  <= jmp_addr_d;
        jreg_addr <= rs_val;
      end
    end
  end

  assign br_taken   = (kind_q == RDIR_BRANCH);
  assign jmp_taken  = (kind_q == RDIR_JUMP);
  assign jreg_taken = (kind_q == RDIR_JREG);
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic [5:0]       opcode,
  input logic [XLEN-1:0]  rs_val,
  input logic [XLEN-1:0]  rt_val,
  input logic [TGT_W-1:0] jtarget,
  input logic [XLEN-1:0]  slot_pc,
  input logic             br_taken,
  input logic             jmp_taken,
  input logic             jreg_taken,
  input logic [XLEN-1:0]  jmp_addr,
  input logic [XLEN-1:0]  jreg_addr
);
  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({br_taken, jmp_taken, jreg_taken})); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !(br_taken || jmp_taken || jreg_taken)); // R8

  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && opcode == 6'd4 && rs_val == rt_val) |=> br_taken); // R2

  AST_JUMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && (opcode == 6'd2 || opcode == 6'd3)) |=>
      (jmp_taken && jmp_addr[TGT_W+1:2] == $past(jtarget))); // R5

  AST_JREG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> jreg_addr == $past(rs_val)); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && $past(rst_n)) |=> ($stable(jreg_addr) && $stable(jmp_addr))); // R9

  logic unused_ok;
  assign unused_ok = ^slot_pc;
endmodule

bind branch_resolver branch_resolver_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [4:0]  rt_sel = '0;
  logic [15:0] imm = '0;
  logic [25:0] jtarget = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] slot_pc = '0;
  logic        br_taken, jmp_taken, jreg_taken;
  logic [31:0] br_addr, jmp_addr, jreg_addr;

  int checks = 0;
  int failures = 0;
  logic [31:0] e_br = '0, e_jmp = '0, e_jreg = '0;

  always #10 clk = ~clk;

  branch_resolver u_dut (.*);

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // 0 none, 1 branch, 2 jump, 3 register jump
  function automatic int model_kind(input logic [5:0] op, input logic [5:0] fn,
                                    input logic [4:0] sel, input logic [31:0] a,
                                    input logic [31:0] b);
    int sa;
    sa = $signed(a);
    case (op)
      6'd0: return (fn == 6'd8 || fn == 6'd9) ? 3 : 0;
      6'd1: if (sel == 5'd0) return (sa < 0) ? 1 : 0;
            else if (sel == 5'd1) return (sa >= 0) ? 1 : 0;
            else return 0;
      6'd2, 6'd3: return 2;
      6'd4: return (a == b) ? 1 : 0;
      6'd5: return (a != b) ? 1 : 0;
      6'd6: return (sa <= 0) ? 1 : 0;
      6'd7: return (sa > 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic v);
    if (!v) return "R8";
    case (op)
      6'd4, 6'd5: return "R2";
      6'd6, 6'd7: return "R3";
      6'd1: return "R4";
      6'd2, 6'd3: return "R5";
      6'd0: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check_val(input string req, input string what,
                           input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [5:0] op, input logic [5:0] fn,
                      input logic [4:0] sel, input logic [15:0] im, input logic [25:0] jt,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc);
    int k;
    id_valid = v; opcode = op; funct = fn; rt_sel = sel; imm = im;
    jtarget = jt; rs_val = a; rt_val = b; slot_pc = pc;
    k = v ? model_kind(op, fn, sel, a, b) : 0;
    if (v) begin
      e_br   = pc + {{14{im[15]}}, im, 2'b00};
      e_jmp  = {pc[31:28], jt, 2'b00};
      e_jreg = a;
    end
    @(posedge clk);
    @(negedge clk);
    check_val(tag_of(op, v), "flags", {29'd0, br_taken, jmp_taken, jreg_taken},
              {29'd0, k == 1, k == 2, k == 3});
    check_val(v ? "R7" : "R9", "br_addr", br_addr, e_br);
    check_val(v ? "R5" : "R9", "jmp_addr", jmp_addr, e_jmp);
    check_val(v ? "R6" : "R9", "jreg_addr", jreg_addr, e_jreg);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check_val("R1", "flags in reset", {29'd0, br_taken, jmp_taken, jreg_taken}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1", "flags after reset", {29'd0, br_taken, jmp_taken, jreg_taken}, 32'd0);
    check_val("R1", "br_addr after reset", br_addr, 32'd0);
    check_val("R1", "jreg_addr after reset", jreg_addr, 32'd0);

    // directed corner cases
    step(1, 6'd4, 0, 0, 16'h0004, 0, 32'h1234, 32'h1234, 32'h0000_1000); // R2 equal
    step(1, 6'd5, 0, 0, 16'hFFFF, 0, 32'h1234, 32'h1234, 32'h0000_1000); // R2 ne, R7 negative
    step(1, 6'd7, 0, 0, 0, 0, 32'd0, 0, 32'h10);                         // R3 zero
    step(1, 6'd7, 0, 0, 0, 0, 32'd1, 0, 32'h10);                         // R3 one
    step(1, 6'd6, 0, 0, 0, 0, 32'h8000_0000, 0, 32'h10);                 // R3 min
    step(1, 6'd6, 0, 0, 0, 0, 32'd1, 0, 32'h10);
    step(1, 6'd1, 0, 5'd1, 0, 0, 32'd0, 0, 32'h20);                      // R4 bgez zero
    step(1, 6'd1, 0, 5'd0, 0, 0, 32'hFFFF_FFFF, 0, 32'h20);              // R4 bltz -1
    step(1, 6'd1, 0, 5'd2, 0, 0, 32'hFFFF_FFFF, 0, 32'h20);              // R4 other sel
    step(1, 6'd3, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 32'hA000_0004);           // R5
    step(1, 6'd0, 6'd9, 0, 0, 0, 32'hDEAD_BEEC, 0, 32'h30);              // R6
    step(1, 6'd0, 6'd10, 0, 0, 0, 32'hDEAD_BEEC, 0, 32'h30);             // R6 other funct
    step(0, 6'd2, 0, 0, 16'h7FFF, 26'h1, 32'h5, 0, 32'hFFFF_0000);       // R9 idle hold
    step(1, 6'd4, 0, 0, 16'h7FFF, 0, 0, 0, 32'hFFFF_FFF0);               // R7 wrap

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      logic [31:0] a, b;
      int pick;
      op = 6'($urandom_range(0, 9));
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 32'd0;
        1: a = 32'd1;
        2: a = 32'hFFFF_FFFF;
        3: a = 32'h8000_0000;
        default: a = $urandom;
      endcase
      b = ($urandom_range(0, 1) == 1) ? a : $urandom;
      step($urandom_range(0, 7) != 0, op, 6'($urandom_range(7, 10)),
           5'($urandom_range(0, 3)), 16'($urandom), 26'($urandom), a, b, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule